// File: doc/BRIEF.md
# Address-Tiled Memory Bank Selector

This block assembles one logical memory from a grid of small RAM tiles. Each tile holds 2^TILE_ABITS words of TILE_DBITS bits. The grid has as many tile rows as the depth needs and as many tile columns as the width needs. Every tile receives the low address bits. The upper address bits pick the tile row that takes a write and the tile row whose output is returned by a read. The last column is trimmed to the bits that remain of the logical width.

The block has one write port with lane enables and one synchronous read port with a read enable, both on a single clock. On the read side, the row decision is captured in a registered set of row-match flags. These flags update only while the read enable is high. A parallel one-hot OR mux uses them to pick one tile output per column, so the returned word always lines up with the tile data captured at the same edge. The depth does not have to be a power of two. Addresses in the last, partly used tile row behave like any other address.

Top module: `tiled_mem`

## Requirements
- R1: The grid has ceil(DEPTH / 2^TILE_ABITS) tile rows and ceil(WIDTH / TILE_DBITS) tile columns, and every address from 0 to DEPTH-1 stores and returns a full WIDTH-bit word. This includes the addresses in the final, partly used row.
- R2: A read issued with rd_en high at a clock edge presents the addressed word on rd_data right after that same edge. rd_data then keeps that word until the next enabled read.
- R3: Write lanes are LANE_W = TILE_DBITS / TILE_LANES bits wide. Bit k of wr_be writes data bits [k*LANE_W +: LANE_W]. Lanes whose enable bit is clear keep their previous contents.
- R4: A write changes only the addressed word. An address that shares the same low TILE_ABITS bits but lies in a different tile row is left untouched.
- R5: While rd_en is low, rd_data does not change. This holds even when rd_addr changes or a write hits the word that was last read.
- R6: When a read and a write target the same address in the same cycle, the read returns the contents from before the write. A later read returns the new contents.
- R7: After reset, and until the first enabled read, rd_data is zero.
- R8: A write with wr_be all zero changes no stored word.
- R9: An address whose upper bits match no tile row (at or above ROWS * 2^TILE_ABITS) is ignored by a write. A read of such an address returns zero, because no row flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read row flags |
| wr_addr | input | ADDR_W | Write word address |
| wr_be | input | BE_W | Write lane enables, one bit per LANE_W data bits |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | WIDTH | Read data, valid after the enabled edge |

## Verification
The bench writes to the same low address in all three tile rows. A design that decoded the upper bits wrongly would overwrite a neighbour and fail those reads. The last partial row and an address past all rows are covered as well: in the first case a wrong row count loses the word, and in the second a missing gate corrupts word 5, 21 or 37. Partial-lane writes and an all-zero enable catch enable slices taken from the wrong column. A read that is held while its address moves and its word is rewritten exposes a mux driven by the live address rather than the registered flags. A read and write to one address in the same cycle exposes write-first behaviour.

// File: rtl/tm_pkg.sv
package tm_pkg;

   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int addr_width(input int depth, input int tile_abits);
      int nat;
      nat = (depth > 1) ? $clog2(depth) : 1;
      return (nat > tile_abits) ? nat : tile_abits;
   endfunction

endpackage

// File: rtl/tm_tile.sv
module tm_tile #(
   parameter int ABITS  = 4,
   parameter int DBITS  = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 4
) (
   input  logic             clk,
   input  logic [LANES-1:0] we,
   input  logic [ABITS-1:0] waddr,
   input  logic [DBITS-1:0] wdata,
   input  logic             re,
   input  logic [ABITS-1:0] raddr,
   output logic [DBITS-1:0] rdata
);
   localparam int WORDS = 2 ** ABITS;

   logic [DBITS-1:0] store [WORDS];

   initial begin : tile_prm_chk
      assert (LANES * LANE_W == DBITS)
         else $error("tile lanes do not cover the tile width");
   end

   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (we[l]) store[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/tm_row_sel.sv
module tm_row_sel #(
   parameter int ROWS = 3,
   parameter int UW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [UW-1:0]   wr_up,
   input  logic            rd_en,
   input  logic [UW-1:0]   rd_up,
   output logic [ROWS-1:0] wr_hit,
   output logic [ROWS-1:0] rd_flag
);
   logic [ROWS-1:0] rd_hit;

   for (genvar r = 0; r < ROWS; r++) begin : g_cmp
      assign wr_hit[r] = (wr_up == UW'(r));
      assign rd_hit[r] = (rd_up == UW'(r));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_flag <= '0;
      else if (rd_en) rd_flag <= rd_hit;
      else            rd_flag <= rd_flag;
   end

   // R4
   wr_rows_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit));

   // R9
   wr_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(wr_up) >= ROWS) |-> (wr_hit == '0));

   // R1
   rd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (int'(rd_up) < ROWS)) |=> $onehot(rd_flag));

   // R9
   rd_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (int'(rd_up) >= ROWS)) |=> (rd_flag == '0));

endmodule

// File: rtl/tm_col_mux.sv
module tm_col_mux #(
   parameter int ROWS  = 3,
   parameter int DBITS = 8
) (
   input  logic [ROWS-1:0]       sel,
   input  logic [ROWS*DBITS-1:0] din,
   output logic [DBITS-1:0]      dout
);
   always_comb begin
      dout = '0;
      for (int r = 0; r < ROWS; r++) begin
         dout = dout | ({DBITS{sel[r]}} & din[r*DBITS +: DBITS]);
      end
   end
endmodule

// File: rtl/tiled_mem.sv
module tiled_mem #(
   parameter int DEPTH      = 40,
   parameter int WIDTH      = 12,
   parameter int TILE_ABITS = 4,
   parameter int TILE_DBITS = 8,
   parameter int TILE_LANES = 2,
   parameter int ADDR_W     = tm_pkg::addr_width(DEPTH, TILE_ABITS),
   parameter int BE_W       = WIDTH / (TILE_DBITS / TILE_LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]  rd_data
);
   localparam int LANE_W = TILE_DBITS / TILE_LANES;
   localparam int ROWS   = tm_pkg::cdiv(DEPTH, 2 ** TILE_ABITS);
   localparam int COLS   = tm_pkg::cdiv(WIDTH, TILE_DBITS);
   localparam int UBITS  = ADDR_W - TILE_ABITS;
   localparam int UW     = (UBITS > 0) ? UBITS : 1;

   initial begin : top_prm_chk
      assert (TILE_DBITS % TILE_LANES == 0)
         else $error("tile width must split into whole lanes");
      assert (WIDTH % LANE_W == 0)
         else $error("logical width must be a whole number of lanes");
      assert (ADDR_W == tm_pkg::addr_width(DEPTH, TILE_ABITS))
         else $error("ADDR_W must keep its derived value");
      assert (BE_W * LANE_W == WIDTH)
         else $error("BE_W must keep its derived value");
   end

   logic [UW-1:0]         wr_up;
   logic [UW-1:0]         rd_up;
   logic [ROWS-1:0]       wr_hit;
   logic [ROWS-1:0]       rd_flag;
   logic [TILE_ABITS-1:0] wr_lo;
   logic [TILE_ABITS-1:0] rd_lo;

   assign wr_lo = wr_addr[TILE_ABITS-1:0];
   assign rd_lo = rd_addr[TILE_ABITS-1:0];

   if (UBITS > 0) begin : g_upper
      assign wr_up = wr_addr[ADDR_W-1:TILE_ABITS];
      assign rd_up = rd_addr[ADDR_W-1:TILE_ABITS];
   end else begin : g_single_row
      assign wr_up = '0;
      assign rd_up = '0;
   end

   tm_row_sel #(.ROWS(ROWS), .UW(UW)) u_row_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_up   (wr_up),
      .rd_en   (rd_en),
      .rd_up   (rd_up),
      .wr_hit  (wr_hit),
      .rd_flag (rd_flag)
   );

   for (genvar d = 0; d < COLS; d++) begin : g_col
      localparam int BASE = d * TILE_DBITS;
      localparam int CW   = (d == COLS - 1) ? (WIDTH - BASE) : TILE_DBITS;
      localparam int CL   = CW / LANE_W;
      localparam int EB   = BASE / LANE_W;

      logic [ROWS*CW-1:0] col_q;
      logic [CW-1:0]      col_out;

      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [CL-1:0] tile_we;
         assign tile_we = wr_hit[r] ? wr_be[EB +: CL] : '0;

         tm_tile #(
            .ABITS  (TILE_ABITS),
            .DBITS  (CW),
            .LANES  (CL),
            .LANE_W (LANE_W)
         ) u_tile (
            .clk   (clk),
            .we    (tile_we),
            .waddr (wr_lo),
            .wdata (wr_data[BASE +: CW]),
            .re    (rd_en),
            .raddr (rd_lo),
            .rdata (col_q[r*CW +: CW])
         );
      end

      tm_col_mux #(.ROWS(ROWS), .DBITS(CW)) u_mux (
         .sel  (rd_flag),
         .din  (col_q),
         .dout (col_out)
      );

      assign rd_data[BASE +: CW] = col_out;
   end

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R7
   rd_reset_chk: assert property (@(posedge clk)
      !rst_n |=> (rd_data == '0));

endmodule

// File: tb/tiled_mem_bench.sv
module tiled_mem_bench;
   localparam int DEPTH = 40;
   localparam int WIDTH = 12;
   localparam int AW    = 6;
   localparam int BEW   = 3;
   localparam int LW    = 4;
   localparam int LIMIT = 48;   // rows * tile words

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    wr_addr = '0;
   logic [BEW-1:0]   wr_be = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             rd_en = 1'b0;
   logic [AW-1:0]    rd_addr = '0;
   logic [WIDTH-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [WIDTH-1:0] model [64];

   always #5 clk = ~clk;

   tiled_mem u_tiled_mem (
      .clk (clk), .rst_n (rst_n), .wr_addr (wr_addr), .wr_be (wr_be),
      .wr_data (wr_data), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
   );

   // {is_read, addr[5:0], be[2:0], data[11:0]}
   localparam logic [21:0] VEC [19] = '{
      {1'b0, 6'd0,  3'b111, 12'hABC},
      {1'b0, 6'd15, 3'b111, 12'h123},
      {1'b0, 6'd16, 3'b111, 12'h456},
      {1'b0, 6'd39, 3'b111, 12'hFED},
      {1'b0, 6'd32, 3'b111, 12'h0F0},
      {1'b0, 6'd21, 3'b111, 12'h777},
      {1'b0, 6'd21, 3'b010, 12'h0A0},
      {1'b1, 6'd0,  3'b000, 12'h000},
      {1'b1, 6'd15, 3'b000, 12'h000},
      {1'b1, 6'd16, 3'b000, 12'h000},
      {1'b1, 6'd39, 3'b000, 12'h000},
      {1'b1, 6'd32, 3'b000, 12'h000},
      {1'b1, 6'd21, 3'b000, 12'h000},
      {1'b0, 6'd5,  3'b111, 12'h555},
      {1'b1, 6'd21, 3'b000, 12'h000},
      {1'b1, 6'd5,  3'b000, 12'h000},
      {1'b0, 6'd37, 3'b111, 12'h333},
      {1'b1, 6'd5,  3'b000, 12'h000},
      {1'b1, 6'd37, 3'b000, 12'h000}
   };

   task automatic check(input string req, input logic [WIDTH-1:0] act,
                        input logic [WIDTH-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [WIDTH-1:0] expect_at(input int a);
      return (a < LIMIT) ? model[a] : '0;
   endfunction

   task automatic model_write(input int a, input logic [BEW-1:0] be,
                              input logic [WIDTH-1:0] d);
      if (a < LIMIT) begin
         for (int l = 0; l < BEW; l++)
            if (be[l]) model[a][l*LW +: LW] = d[l*LW +: LW];
      end
   endtask

   task automatic do_write(input int a, input logic [BEW-1:0] be,
                           input logic [WIDTH-1:0] d);
      wr_addr = AW'(a); wr_be = be; wr_data = d;
      step();
      wr_be = '0;
      model_write(a, be, d);
   endtask

   task automatic do_read(input string req, input int a);
      rd_en = 1'b1; rd_addr = AW'(a);
      step();
      rd_en = 1'b0;
      check(req, rd_data, expect_at(a));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [WIDTH-1:0] held;
      for (int i = 0; i < 64; i++) model[i] = '0;
      repeat (3) step();
      // R7: reset state
      check("R7 reset", rd_data, 12'h000);
      rst_n = 1'b1;
      step();
      check("R7 idle after reset", rd_data, 12'h000);

      // R1 R2 R3 R4: table walk
      foreach (VEC[i]) begin
         if (VEC[i][21])
            do_read("R1 R2 R3 R4 table read", int'(VEC[i][20:15]));
         else
            do_write(int'(VEC[i][20:15]), VEC[i][14:12], VEC[i][11:0]);
      end

      // R5: hold while rd_en low, address moves, word rewritten
      do_read("R2 read before hold", 0);
      held = rd_data;
      rd_addr = AW'(15);
      do_write(0, 3'b111, 12'h111);
      check("R5 hold after write", rd_data, held);
      step();
      check("R5 hold idle", rd_data, held);
      do_read("R5 new word visible", 0);

      // R6: read and write same address, same cycle
      rd_en = 1'b1; rd_addr = AW'(16);
      wr_addr = AW'(16); wr_be = 3'b111; wr_data = 12'h222;
      step();
      rd_en = 1'b0; wr_be = '0;
      check("R6 old contents", rd_data, 12'h456);
      model_write(16, 3'b111, 12'h222);
      do_read("R6 new contents", 16);

      // R8: all-zero lane enable
      do_write(15, 3'b000, 12'hFFF);
      do_read("R8 zero enable", 15);

      // R9: address beyond every row
      do_write(53, 3'b111, 12'hEEE);
      do_read("R9 row0 intact", 5);
      do_read("R9 row1 intact", 21);
      do_read("R9 row2 intact", 37);
      do_read("R9 outside reads zero", 53);

      // R3: single-lane writes in the last partial row
      do_write(39, 3'b100, 12'h9AB);
      do_read("R3 upper lane", 39);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule